// File: doc/BRIEF.md
# Dispatch Steering Unit

This unit sits between register renaming and the scheduling structures of an out-of-order core. Each cycle it receives a group of up to `W` renamed instruction slots. Every slot carries a valid bit, a squashed flag and a three-bit class code. The unit decides, slot by slot and in slot order, which destinations receive the instruction. The possible destinations are the issue queue, the load/store queue and the queue that holds non-speculative work until commit. It also says which completion flags are set on the instruction. The queues themselves live outside; the unit only produces one enable vector per destination and one per flag.

The free-entry count of the issue queue is supplied from outside. It is spent within the cycle, so a later slot sees the entries taken by earlier slots of the same group. When a slot that needs an issue-queue entry finds none left, the unit raises a block request and a stall request. It dispatches nothing from that slot onward.

A two-state controller governs the unit:
- `ST_RUN`: groups are processed.
- `ST_HOLD`: stall is held high and the input group is ignored.

There are two transitions:
- `T_BLOCK` goes from `ST_RUN` to `ST_HOLD` on a block request.
- `T_RESUME` goes from `ST_HOLD` to `ST_RUN` at the first clock edge that sees a non-zero free count.

Top module: `dispatch_steer`

## Requirements
- R1: Slots are examined from index 0 upward; the first slot whose valid bit is 0 ends the group, and no slot at or above it gets any enable, even if its own valid bit is 1.
- R2: A valid slot with its squashed flag set gets no enable of any kind, and the slots after it are still examined.
- R3: Class code 1 (load) sets the load/store-queue enable and the issue-queue enable of its slot and uses one issue-queue entry.
- R4: Class code 2 (store) sets the load/store-queue enable, the non-speculative-queue enable and the can-commit flag, and never the issue-queue enable.
- R5: Class code 3 (non-speculative) sets only the non-speculative-queue enable and the can-commit flag.
- R6: Class code 4 (nop) sets only the tail-advance, issued, executed and can-commit outputs, and uses no issue-queue entry, even when the free count is 0.
- R7: Class codes 0, 5, 6 and 7 are ordinary and set only the issue-queue enable. A load or ordinary slot that finds the remaining free count at 0 raises `block_req` and `stall_req` in the same cycle; that slot and every later slot get no enable; earlier slots keep theirs.
- R8: The number of issue-queue enables in a cycle never exceeds `iq_free`, and each earlier load or ordinary slot reduces the count seen by later slots.
- R9: After a cycle with `block_req`, the unit is in `ST_HOLD`: `stall_req` is 1 and all enables are 0. It returns to `ST_RUN` for the cycle after the first edge at which `iq_free` is non-zero.
- R10: During and right after reset the unit is in `ST_RUN` with `stall_req` and `block_req` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_valid | input | W | Slot valid bits |
| grp_squash | input | W | Slot squashed flags |
| grp_class | input | 3*W | Slot class codes, slot i at bits 3i+2:3i |
| iq_free | input | $clog2(IQ_DEPTH+1) | Free issue-queue entries this cycle |
| iq_ins | output | W | Insert slot into issue queue |
| lsq_ins | output | W | Reserve load/store-queue entry |
| nsq_ins | output | W | Insert into non-speculative queue |
| iq_tail_adv | output | W | Advance issue-queue tail for a nop |
| set_issued | output | W | Mark slot issued |
| set_executed | output | W | Mark slot executed |
| set_can_commit | output | W | Mark slot can-commit |
| block_req | output | 1 | Group hit a full issue queue this cycle |
| stall_req | output | 1 | Ask upstream to hold its group |

## Verification
Homogeneous groups of each class show that every class routes to its own destinations, including nops while the free count is zero. Groups with a hole in the valid bits or a squashed slot in the middle distinguish stopping the group from skipping a slot. A group of ordinary slots with fewer free entries than slots checks the within-cycle accounting and the block point. The cycles that follow check the hold and resume transitions. A long stretch of random groups then mixes all classes, holes, squashes and small free counts against the model.

// File: rtl/dsu_pkg.sv
`timescale 1ns/1ps
package dsu_pkg;

    localparam int CLS_W = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_OTHER   = 3'd0,
        CLS_LOAD    = 3'd1,
        CLS_STORE   = 3'd2,
        CLS_NONSPEC = 3'd3,
        CLS_NOP     = 3'd4
    } slot_class_e;

    typedef struct packed {
        logic to_iq;
        logic to_lsq;
        logic to_nsq;
        logic tail_adv;
        logic issued;
        logic executed;
        logic can_commit;
    } route_t;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } ctrl_state_e;

endpackage

// File: rtl/dsu_slot_decode.sv
`timescale 1ns/1ps
module dsu_slot_decode
    import dsu_pkg::*;
(
    input  logic [CLS_W-1:0] cls_i,
    output route_t           route_o
);

    always_comb begin
        route_o = '0;
        case (cls_i)
            CLS_LOAD: begin
                route_o.to_lsq = 1'b1;
                route_o.to_iq  = 1'b1;
            end
            CLS_STORE: begin
                route_o.to_lsq     = 1'b1;
                route_o.to_nsq     = 1'b1;
                route_o.can_commit = 1'b1;
            end
            CLS_NONSPEC: begin
                route_o.to_nsq     = 1'b1;
                route_o.can_commit = 1'b1;
            end
            CLS_NOP: begin
                route_o.tail_adv   = 1'b1;
                route_o.issued     = 1'b1;
                route_o.executed   = 1'b1;
                route_o.can_commit = 1'b1;
            end
            default: begin
                route_o.to_iq = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/dsu_scan.sv
`timescale 1ns/1ps
module dsu_scan
    import dsu_pkg::*;
#(
    parameter int W  = 4,
    parameter int CW = 5
) (
    input  logic          enable_i,
    input  logic [W-1:0]  valid_i,
    input  logic [W-1:0]  squash_i,
    input  route_t        routes_i [W],
    input  logic [CW-1:0] free_i,
    output route_t        grant_o  [W],
    output logic          block_o
);

    always_comb begin
        logic          alive;
        logic [CW-1:0] left;
        logic          live_slot;
        logic          starved;
        alive   = enable_i;
        left    = free_i;
        block_o = 1'b0;
        for (int i = 0; i < W; i++) begin
            grant_o[i] = '0;
            live_slot  = alive && valid_i[i] && !squash_i[i];
            starved    = routes_i[i].to_iq && (left == '0);
            if (alive && !valid_i[i]) begin
                alive = 1'b0;
            end else if (live_slot && starved) begin
                block_o = 1'b1;
                alive   = 1'b0;
            end else if (live_slot) begin
                grant_o[i] = routes_i[i];
                if (routes_i[i].to_iq) begin
                    left = left - CW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/dsu_ctrl.sv
`timescale 1ns/1ps
module dsu_ctrl
    import dsu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic block_i,
    input  logic free_nz_i,
    output logic run_o,
    output logic stall_o
);

    ctrl_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:  if (block_i)   state_nx = ST_HOLD;  // T_BLOCK
            ST_HOLD: if (free_nz_i) state_nx = ST_RUN;   // T_RESUME
            default: state_nx = ST_RUN;
        endcase
    end

    always_comb begin
        run_o   = 1'b0;
        stall_o = 1'b0;
        unique case (state)
            ST_RUN: begin
                run_o   = 1'b1;
                stall_o = block_i;
            end
            ST_HOLD: begin
                stall_o = 1'b1;
            end
            default: ;
        endcase
    end

    p_block_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        block_i |-> stall_o);

    p_block_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        block_i |=> (state == ST_HOLD && stall_o));

    p_resume_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && free_nz_i) |=> run_o);

    p_hold_no_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_o |-> !block_i);

endmodule

// File: rtl/dispatch_steer.sv
`timescale 1ns/1ps
module dispatch_steer
    import dsu_pkg::*;
#(
    parameter int W        = 4,
    parameter int IQ_DEPTH = 16,
    localparam int CW      = $clog2(IQ_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     grp_valid,
    input  logic [W-1:0]     grp_squash,
    input  logic [3*W-1:0]   grp_class,
    input  logic [CW-1:0]    iq_free,
    output logic [W-1:0]     iq_ins,
    output logic [W-1:0]     lsq_ins,
    output logic [W-1:0]     nsq_ins,
    output logic [W-1:0]     iq_tail_adv,
    output logic [W-1:0]     set_issued,
    output logic [W-1:0]     set_executed,
    output logic [W-1:0]     set_can_commit,
    output logic             block_req,
    output logic             stall_req
);

    route_t dec   [W];
    route_t grant [W];
    logic   run;

    for (genvar i = 0; i < W; i++) begin : g_slot
        dsu_slot_decode u_dec (
            .cls_i   (grp_class[i*CLS_W +: CLS_W]),
            .route_o (dec[i])
        );
        assign iq_ins[i]         = grant[i].to_iq;
        assign lsq_ins[i]        = grant[i].to_lsq;
        assign nsq_ins[i]        = grant[i].to_nsq;
        assign iq_tail_adv[i]    = grant[i].tail_adv;
        assign set_issued[i]     = grant[i].issued;
        assign set_executed[i]   = grant[i].executed;
        assign set_can_commit[i] = grant[i].can_commit;

        p_invalid_stop_r1: assert property (@(posedge clk) disable iff (!rst_n)
            !grp_valid[i] |->
                (((iq_ins | lsq_ins | nsq_ins | iq_tail_adv | set_can_commit) >> i) == '0));

        p_squash_skip_r2: assert property (@(posedge clk) disable iff (!rst_n)
            grp_squash[i] |->
                !(iq_ins[i] || lsq_ins[i] || nsq_ins[i] || iq_tail_adv[i] || set_can_commit[i]));
    end

    dsu_scan #(.W(W), .CW(CW)) u_scan (
        .enable_i (run),
        .valid_i  (grp_valid),
        .squash_i (grp_squash),
        .routes_i (dec),
        .free_i   (iq_free),
        .grant_o  (grant),
        .block_o  (block_req)
    );

    dsu_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .block_i   (block_req),
        .free_nz_i (|iq_free),
        .run_o     (run),
        .stall_o   (stall_req)
    );

    p_no_iq_for_deferred_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (iq_ins & nsq_ins) == '0);

    p_capacity_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(iq_ins) <= int'(iq_free));

    p_hold_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_req && !block_req) |->
            ((iq_ins | lsq_ins | nsq_ins | iq_tail_adv | set_can_commit) == '0));

endmodule

// File: tb/tb_dispatch_steer.sv
`timescale 1ns/1ps
module tb_dispatch_steer;

    localparam int W  = 4;
    localparam int CW = 5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [W-1:0]   grp_valid = '0;
    logic [W-1:0]   grp_squash = '0;
    logic [3*W-1:0] grp_class = '0;
    logic [CW-1:0]  iq_free = '0;
    logic [W-1:0]   iq_ins, lsq_ins, nsq_ins, iq_tail_adv;
    logic [W-1:0]   set_issued, set_executed, set_can_commit;
    logic           block_req, stall_req;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  held    = 0;
    bit  done    = 0;

    always #2 clk = ~clk;

    dispatch_steer #(.W(W), .IQ_DEPTH(16)) dut (
        .clk(clk), .rst_n(rst_n),
        .grp_valid(grp_valid), .grp_squash(grp_squash),
        .grp_class(grp_class), .iq_free(iq_free),
        .iq_ins(iq_ins), .lsq_ins(lsq_ins), .nsq_ins(nsq_ins),
        .iq_tail_adv(iq_tail_adv), .set_issued(set_issued),
        .set_executed(set_executed), .set_can_commit(set_can_commit),
        .block_req(block_req), .stall_req(stall_req)
    );

    function automatic logic [3*W-1:0] pack4(int a, int b, int c, int d);
        return {3'(d), 3'(c), 3'(b), 3'(a)};
    endfunction

    task automatic cycle(input logic [W-1:0] v, input logic [W-1:0] s,
                         input logic [3*W-1:0] c, input int free, input string tag);
        logic [W-1:0] e_iq, e_lsq, e_nsq, e_tail, e_iss, e_exe, e_cc;
        logic e_blk, e_stall;
        logic [7*W+1:0] got, exp;
        int left;
        @(negedge clk);
        grp_valid = v; grp_squash = s; grp_class = c; iq_free = CW'(free);
        #1;
        e_iq = '0; e_lsq = '0; e_nsq = '0; e_tail = '0;
        e_iss = '0; e_exe = '0; e_cc = '0; e_blk = 0;
        if (!held) begin
            left = free;
            for (int i = 0; i < W; i++) begin
                int k;
                bit needs;
                if (!v[i]) break;
                if (s[i]) continue;
                k = int'(c[i*3 +: 3]);
                needs = (k != 2 && k != 3 && k != 4);
                if (needs && left == 0) begin e_blk = 1; break; end
                case (k)
                    1: begin e_iq[i] = 1; e_lsq[i] = 1; end
                    2: begin e_lsq[i] = 1; e_nsq[i] = 1; e_cc[i] = 1; end
                    3: begin e_nsq[i] = 1; e_cc[i] = 1; end
                    4: begin e_tail[i] = 1; e_iss[i] = 1; e_exe[i] = 1; e_cc[i] = 1; end
                    default: e_iq[i] = 1;
                endcase
                if (needs) left--;
            end
        end
        e_stall = held || e_blk;
        got = {iq_ins, lsq_ins, nsq_ins, iq_tail_adv, set_issued, set_executed,
               set_can_commit, block_req, stall_req};
        exp = {e_iq, e_lsq, e_nsq, e_tail, e_iss, e_exe, e_cc, e_blk, e_stall};
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h (held=%0d)", tag, got, exp, held);
        end
        if (!held && e_blk) held = 1;
        else if (held && free != 0) held = 0;
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // R10: reset state
        @(negedge clk);
        n_tests++;
        if (stall_req !== 1'b0 || block_req !== 1'b0) begin
            n_fail++;
            $display("FAIL R10: got stall=%b block=%b expected 0 0", stall_req, block_req);
        end
        rst_n = 1'b1;
        cycle('0, '0, '0, 0, "R10");

        cycle(4'b1111, '0, pack4(1,1,1,1), 8, "R3");
        cycle(4'b1111, '0, pack4(2,2,2,2), 0, "R4");
        cycle(4'b1111, '0, pack4(3,3,3,3), 0, "R5");
        cycle(4'b1111, '0, pack4(4,4,4,4), 0, "R6");
        cycle(4'b1011, '0, pack4(0,1,2,0), 8, "R1");
        cycle(4'b0111, '0, pack4(1,4,3,0), 8, "R1");
        cycle(4'b1111, 4'b0010, pack4(0,0,2,1), 8, "R2");
        cycle(4'b1111, '0, pack4(5,6,7,0), 4, "R7");
        cycle(4'b1111, '0, pack4(0,1,4,0), 2, "R8");
        cycle(4'b1111, '0, pack4(0,0,0,0), 2, "R7");
        cycle(4'b1111, '0, pack4(4,4,4,4), 0, "R9");
        cycle(4'b1111, '0, pack4(2,2,2,2), 0, "R9");
        cycle(4'b1111, '0, pack4(0,0,0,0), 3, "R9");
        cycle(4'b1111, '0, pack4(0,3,0,0), 3, "R9");
        cycle(4'b1111, '0, pack4(4,1,4,2), 0, "R7");
        cycle(4'b1111, '0, pack4(4,4,4,4), 1, "R9");

        for (int n = 0; n < 400; n++) begin
            logic [3*W-1:0] c;
            for (int i = 0; i < W; i++) c[i*3 +: 3] = 3'($urandom_range(0, 7));
            cycle(4'($urandom_range(0, 15) | (n % 3 == 0 ? 15 : 0)),
                  4'($urandom_range(0, 15) & $urandom_range(0, 15)),
                  c, $urandom_range(0, 4), "R8");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule